// File: doc/BRIEF.md
# Memory Test Pattern Generator and Checker

This block drives a stream of 32-bit test words toward a memory under test and checks the words that come back against the same sequence, rebuilt independently on the read side. A 3-bit mode code, captured when a run starts, selects one of six diagnostic patterns: a plain count, a pseudo-random sequence, a walking one, a walking zero, an all-ones/all-zeros swing and an alternating-bit checkerboard. Each pattern exposes a different class of fault: address aliasing, full coverage of line combinations, shorted or stuck data lines, supply stress from simultaneous switching, and crosstalk between neighbouring lines.

The write side offers words on a valid/ready stream and moves to the next word only when a word is accepted. The read side takes one returned word on each cycle where its valid is high and compares it with its own expected word. Differences collect in a sticky per-bit mask. A saturating counter tracks the mismatching beats, and the index of the first bad beat is captured once. Addressing and the memory controller sit outside this block.

Top module: `mem_pattern_engine`

## Requirements
- R1: While `rst` is high, and after it falls until the first start, `wr_valid`, `err_mask`, `err_count` and `first_fail_valid` are all zero.
- R2: A high `start` captures `mode` and `seed`. It restarts both the write and the read sequence at beat index 0 and clears all error state. From the next cycle on it holds `wr_valid` at 1. A read beat presented in the start cycle is not compared and does not advance the read side.
- R3: Mode 0 (count): word n equals n modulo 2^32.
- R4: Mode 1 (pseudo-random): word 0 is the seed, or 1 when the seed is zero. Each following word is the previous word s shifted left by one, with bit 0 set to s[31]^s[21]^s[1]^s[0] (polynomial x^32+x^22+x^2+x+1). The word is never zero.
- R5: Mode 2 (walking one): word n has only bit (n mod 32) set.
- R6: Mode 3 (walking zero): word n has only bit (n mod 32) cleared.
- R7: Mode 4 (full swing): even beats give 0xFFFFFFFF and odd beats give 0x00000000.
- R8: Mode 5 (checkerboard): even beats give 0x55555555 and odd beats give 0xAAAAAAAA.
- R9: Mode codes 6 and 7 produce all-zero words.
- R10: The write word moves to the next beat only on a cycle with `wr_valid` and `wr_ready` both high. Otherwise `wr_data` holds its value.
- R11: Each cycle with `rd_valid` high advances the expected read sequence by one beat and ORs the bitwise XOR of expected and returned data into `err_mask`. Mask bits stay set until `start` or `err_clear`.
- R12: `err_count` rises by one for each read beat with any mismatching bit and holds at its all-ones value once it gets there.
- R13: On the first mismatching beat after a clear, `first_fail_valid` is set and `first_fail_index` takes that beat's read index (0 for the first beat after start). Neither changes on later mismatches.
- R14: `err_clear` zeroes the mask, the count and the first-fail record at the next edge, and a mismatch in the same cycle is dropped. It does not move either sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run: capture mode and seed, restart sequences, clear errors |
| mode | input | 3 | Pattern code, captured at start |
| seed | input | 32 | Pseudo-random start value, captured at start |
| err_clear | input | 1 | Clear the error mask, the count and the first-fail record |
| wr_data | output | 32 | Current write test word |
| wr_valid | output | 1 | Write word offered |
| wr_ready | input | 1 | Write word accepted when high with wr_valid |
| rd_data | input | 32 | Returned data word |
| rd_valid | input | 1 | Returned word present this cycle |
| err_mask | output | 32 | Sticky per-bit mismatch mask |
| err_count | output | CNT_W | Saturating count of mismatching beats |
| first_fail_index | output | 32 | Read index of the first mismatching beat |
| first_fail_valid | output | 1 | A mismatch has been recorded since the last clear |

## Verification
Every mode code, including the two unused ones, is run for more than one full wrap of the walking patterns. Ready and read-valid gaps show that each side advances only on its own accepted beats and not on elapsed cycles. A zero seed checks the substitute start value. Returned data is looped back clean, so that a false error would show up, and then with single- and multi-bit flips on chosen beats. These flips separate the sticky OR of the mask from plain overwrite, the first-fail latch from a last-fail latch, and a saturating count from a wrapping one. Clears that land on a bad beat show that the clear takes priority.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  typedef enum logic [2:0] {
    PM_COUNT    = 3'd0,
    PM_PRBS     = 3'd1,
    PM_WALK1    = 3'd2,
    PM_WALK0    = 3'd3,
    PM_SWING    = 3'd4,
    PM_CHECKER  = 3'd5
  } pmode_e;
endpackage

// File: rtl/mpe_pattern_gen.sv
module mpe_pattern_gen #(
  parameter int W  = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [2:0]    mode_i,
  input  logic [W-1:0]  seed_i,
  input  logic          adv_i,
  output logic [W-1:0]  word_o,
  output logic [IW-1:0] idx_o
);
  import mpe_pkg::*;
  localparam int SHW = $clog2(W);

  logic [2:0]    mode_r;
  logic [IW-1:0] idx_r;
  logic [W-1:0]  lfsr_r;
  logic [W-1:0]  word_r;

  function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
    return {s[W-2:0], s[W-1] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [W-1:0] pattern(input logic [2:0] m,
                                           input logic [IW-1:0] n,
                                           input logic [W-1:0] s);
    logic [W-1:0] walk;
    walk = W'(1) << n[SHW-1:0];
    case (m)
      PM_COUNT:   return W'(n);
      PM_PRBS:    return s;
      PM_WALK1:   return walk;
      PM_WALK0:   return ~walk;
      PM_SWING:   return n[0] ? '0 : '1;
      PM_CHECKER: return n[0] ? {(W/2){2'b10}} : {(W/2){2'b01}};
      default:    return '0;
    endcase
  endfunction

  logic [W-1:0]  seed_eff;
  logic [IW-1:0] idx_nx;
  logic [W-1:0]  lfsr_nx;
  assign seed_eff = (seed_i == '0) ? W'(1) : seed_i;
  assign idx_nx   = idx_r + IW'(1);
  assign lfsr_nx  = lfsr_next(lfsr_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r <= 3'd0;
      idx_r  <= '0;
      lfsr_r <= W'(1);
      word_r <= '0;
    end else if (load_i) begin
      mode_r <= mode_i;
      idx_r  <= '0;
      lfsr_r <= seed_eff;
      word_r <= pattern(mode_i, '0, seed_eff);
    end else if (adv_i) begin
      idx_r  <= idx_nx;
      lfsr_r <= lfsr_nx;
      word_r <= pattern(mode_r, idx_nx, lfsr_nx);
    end
  end

  assign word_o = word_r;
  assign idx_o  = idx_r;

  AST_WALK1_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (mode_r == PM_WALK1) |-> ($countones(word_r) == 1)); // R5
  AST_WALK0_ONECOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_r == PM_WALK0) |-> ($countones(~word_r) == 1)); // R6
  AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (mode_r == PM_PRBS) |-> (word_r != '0)); // R4
endmodule

// File: rtl/mpe_err_track.sv
module mpe_err_track #(
  parameter int W     = 32,
  parameter int IW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             beat_i,
  input  logic [W-1:0]     exp_i,
  input  logic [W-1:0]     act_i,
  input  logic [IW-1:0]    idx_i,
  output logic [W-1:0]     mask_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IW-1:0]    fidx_o,
  output logic             fvld_o
);
  logic [W-1:0] diff;
  assign diff = exp_i ^ act_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      mask_o <= '0;
      cnt_o  <= '0;
      fidx_o <= '0;
      fvld_o <= 1'b0;
    end else if (beat_i && (diff != '0)) begin
      mask_o <= mask_o | diff;
      if (cnt_o != '1) cnt_o <= cnt_o + CNT_W'(1);
      if (!fvld_o) begin
        fvld_o <= 1'b1;
        fidx_o <= idx_i;
      end
    end
  end

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((mask_o | $past(mask_o)) == mask_o)); // R11
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && cnt_o == '1) |=> (cnt_o == '1)); // R12
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && fvld_o) |=> (fvld_o && $stable(fidx_o))); // R13
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (mask_o == '0 && cnt_o == '0 && !fvld_o)); // R14
endmodule

// File: rtl/mem_pattern_engine.sv
module mem_pattern_engine #(
  parameter int W     = 32,
  parameter int IW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       mode,
  input  logic [W-1:0]     seed,
  input  logic             err_clear,
  output logic [W-1:0]     wr_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  input  logic [W-1:0]     rd_data,
  input  logic             rd_valid,
  output logic [W-1:0]     err_mask,
  output logic [CNT_W-1:0] err_count,
  output logic [IW-1:0]    first_fail_index,
  output logic             first_fail_valid
);
  logic          running;
  logic          wr_adv, rd_adv;
  logic [W-1:0]  exp_word;
  logic [IW-1:0] rd_idx, wr_idx;

  assign wr_adv = running && wr_ready && !start;
  assign rd_adv = rd_valid && !start;

  always_ff @(posedge clk) begin
    if (rst)        running <= 1'b0;
    else if (start) running <= 1'b1;
  end
  assign wr_valid = running;

  mpe_pattern_gen #(.W(W), .IW(IW)) u_wr_gen (
    .clk(clk), .rst(rst), .load_i(start), .mode_i(mode), .seed_i(seed),
    .adv_i(wr_adv), .word_o(wr_data), .idx_o(wr_idx)
  );

  mpe_pattern_gen #(.W(W), .IW(IW)) u_rd_gen (
    .clk(clk), .rst(rst), .load_i(start), .mode_i(mode), .seed_i(seed),
    .adv_i(rd_adv), .word_o(exp_word), .idx_o(rd_idx)
  );

  mpe_err_track #(.W(W), .IW(IW), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .clr_i(start || err_clear), .beat_i(rd_adv),
    .exp_i(exp_word), .act_i(rd_data), .idx_i(rd_idx),
    .mask_o(err_mask), .cnt_o(err_count),
    .fidx_o(first_fail_index), .fvld_o(first_fail_valid)
  );

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready && !start) |=> (wr_valid && $stable(wr_data) && $stable(wr_idx))); // R10
  AST_START_VALID: assert property (@(posedge clk) disable iff (rst)
    start |=> (wr_valid && rd_idx == '0 && !first_fail_valid)); // R2
endmodule

// File: tb/mem_pattern_engine_test.sv
`timescale 1ns/1ps
module mem_pattern_engine_test;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst, start, err_clear, wr_ready, rd_valid, wr_valid, first_fail_valid;
  logic [2:0] mode;
  logic [31:0] seed, wr_data, rd_data, err_mask, first_fail_index;
  logic [CW-1:0] err_count;

  always #2.5 clk = ~clk;

  mem_pattern_engine #(.W(32), .IW(32), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .seed(seed),
    .err_clear(err_clear), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .err_mask(err_mask), .err_count(err_count),
    .first_fail_index(first_fail_index), .first_fail_valid(first_fail_valid)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int m_mode = 0, w_n = 0, r_n = 0, m_cnt = 0, m_fidx = 0;
  logic [31:0] w_s = 1, r_s = 1, m_mask = 0;
  bit m_run = 0, m_fvld = 0, last_rdy = 1;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] ref_word(input int m, input int n, input logic [31:0] s);
    case (m)
      0: return 32'(n);
      1: return s;
      2: return 32'h1 << (n % 32);
      3: return ~(32'h1 << (n % 32));
      4: return (n % 2 == 0) ? 32'hFFFF_FFFF : 32'h0;
      5: return (n % 2 == 0) ? 32'h5555_5555 : 32'hAAAA_AAAA;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R6";
      4: return "R7"; 5: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2", 32'(wr_valid), 32'(m_run));
    if (m_run) chk(last_rdy ? mode_tag(m_mode) : "R10", wr_data, ref_word(m_mode, w_n, w_s));
    chk("R11", err_mask, m_mask);
    chk("R12", 32'(err_count), 32'(m_cnt));
    chk("R13", 32'(first_fail_valid), 32'(m_fvld));
    if (m_fvld) chk("R13", first_fail_index, 32'(m_fidx));
  endtask

  // one clock: drive at negedge, update model, compare at next negedge
  task automatic cyc(input bit st, input bit clr, input bit rdv,
                     input logic [31:0] inj, input bit rdy, input int md = 0,
                     input logic [31:0] sd = 0);
    logic [31:0] s0;
    start = st; err_clear = clr; rd_valid = rdv; wr_ready = rdy;
    mode = 3'(md); seed = sd;
    rd_data = ref_word(m_mode, r_n, r_s) ^ inj;
    last_rdy = 1;
    if (st) begin
      s0 = (sd == 0) ? 32'h1 : sd;
      m_mode = md; w_n = 0; r_n = 0; w_s = s0; r_s = s0;
      m_mask = 0; m_cnt = 0; m_fvld = 0; m_fidx = 0; m_run = 1;
    end else begin
      if (m_run && rdy) begin w_n++; w_s = nxt(w_s); end
      if (m_run && !rdy) last_rdy = 0;
      if (clr) begin
        m_mask = 0; m_cnt = 0; m_fvld = 0; m_fidx = 0;
      end else if (rdv && inj != 0) begin
        m_mask |= inj;
        if (m_cnt < (1 << CW) - 1) m_cnt++;
        if (!m_fvld) begin m_fvld = 1; m_fidx = r_n; end
      end
      if (rdv) begin r_n++; r_s = nxt(r_s); end
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; start = 0; err_clear = 0; rd_valid = 0; wr_ready = 0;
    mode = 0; seed = 0; rd_data = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 32'(wr_valid), 0);
    chk("R1", err_mask, 0);
    chk("R1", 32'(err_count), 0);
    chk("R1", 32'(first_fail_valid), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", 32'(wr_valid), 0);

    // every mode, clean loopback, with ready and read gaps (R3..R10)
    for (int md = 0; md < 8; md++) begin
      cyc(1, 0, 1, 32'h0, 1, md, 32'hACE1_0000 + 32'(md)); // R2: start-cycle read ignored
      for (int i = 0; i < 80; i++)
        cyc(0, 0, (i % 4) != 1, 32'h0, (i % 3) != 0);
    end

    // R4: zero seed gives 1
    cyc(1, 0, 0, 0, 1, 1, 32'h0);
    chk("R4", wr_data, 32'h1);
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, 0, 1);

    // R11, R13: sticky mask and first-fail latch, walking one
    cyc(1, 0, 0, 0, 1, 2, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 1);
    cyc(0, 0, 1, 32'h0000_0010, 1);               // first error at index 5
    chk("R13", first_fail_index, 32'd5);
    cyc(0, 0, 0, 32'h8000_0000, 1);               // not a beat: ignored
    chk("R11", err_mask, 32'h0000_0010);
    cyc(0, 0, 1, 32'h0300_0000, 0);
    chk("R11", err_mask, 32'h0300_0010);
    chk("R13", first_fail_index, 32'd5);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0, 1);
    chk("R11", err_mask, 32'h0300_0010);

    // R14: clear wins over a bad beat, sequences keep going
    cyc(0, 1, 1, 32'hFFFF_0000, 1);
    chk("R14", err_mask, 32'h0);
    chk("R14", 32'(first_fail_valid), 0);
    cyc(0, 0, 1, 32'h0000_0001, 1);
    chk("R14", first_fail_index, 32'(r_n - 1));

    // R12: saturation with checkerboard, every beat bad
    cyc(1, 0, 0, 0, 1, 5, 0);
    for (int i = 0; i < 22; i++) cyc(0, 0, 1, 32'(1) << (i % 32), (i % 2) == 0);
    chk("R12", 32'(err_count), 32'((1 << CW) - 1));
    chk("R13", first_fail_index, 32'd0);

    // R2: restart clears errors
    cyc(1, 0, 1, 32'hFFFF_FFFF, 1, 4, 0);
    chk("R2", err_mask, 32'h0);
    chk("R2", wr_data, 32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule